// File: doc/BRIEF.md
# Charger Register Slave on a Two-Wire Management Bus

This block is the host-facing register bank of a battery charger controller. It listens on a two-wire SMBus link as a target, answers the fixed 7-bit address 0x09 (address bytes 0x12 for writes, 0x13 for reads), and supports the Write-Word and Read-Word transfers. Both bus pins are oversampled by the system clock through synchronizers, and the data pin is driven only as an open-drain pull-down enable.

Behind the link sit four writable setting words (an options word, a charge-current limit, a charge-voltage limit and an input-current limit) and two fixed identification words. Every write is filtered before it is stored. Each limit keeps only its converter field, and a charge-current or charge-voltage value outside the allowed range clears the whole word. Two options bits show live status inputs, and the learn-mode bit can be cleared by a pulse from the power-path logic. The stored values and a one-cycle strobe for each word go to the rest of the charger.

Top module: `smb_chg_regs`

## Requirements
- R1: The block acknowledges only address byte 0x12 (write) or 0x13 (read). Any other address byte gets no ACK, and the rest of that transfer is ignored. The block never pulls SDA low while no transfer addressed to it is in progress.
- R2: After reset the words read: options 0xF902 (with both status inputs low), charge current 0x0000, charge voltage 0x0000, input current 0x1000.
- R3: Command 0xFE always reads 0x0040 and command 0xFF always reads 0x001B. Writes to either command change nothing.
- R4: A write to command 0x14 stores only bits 12:6 of the data. If the result is below 0x0080, the word becomes 0x0000.
- R5: A write to command 0x15 stores only bits 14:4 of the data. If the result is below 0x0400 or above 0x4B00, the word becomes 0x0000.
- R6: A write to command 0x3F stores only bits 12:7 of the data.
- R7: In the options word (command 0x12), bit 4 always reflects the adapter-present input and bit 2 always reflects the boost-active input. Written values of those two bits have no effect.
- R8: A one-cycle pulse on learn_done clears options bit 6 on the next clock edge. The other options bits are unchanged.
- R9: Each accepted word write raises exactly one write strobe, the one for the addressed word, for exactly one clock cycle. A stored word changes only in a cycle where its strobe is high.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data is sampled on SCL rising. Each accepted byte is acknowledged in the ninth clock. Word data travels low byte first. A read sends the command byte and then a repeated START with address byte 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock pin level |
| sda_in | input | 1 | Bus data pin level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sts_adapter | input | 1 | Adapter-present status, shown in options bit 4 |
| sts_boost | input | 1 | Boost-active status, shown in options bit 2 |
| learn_done | input | 1 | Pulse that clears options bit 6 |
| opt_q | output | 16 | Options word with live status bits merged |
| ichg_q | output | 16 | Charge-current word |
| vchg_q | output | 16 | Charge-voltage word |
| iin_q | output | 16 | Input-current word |
| wr_opt | output | 1 | Options write strobe |
| wr_ichg | output | 1 | Charge-current write strobe |
| wr_vchg | output | 1 | Charge-voltage write strobe |
| wr_iin | output | 1 | Input-current write strobe |

## Verification
The assertions check the following on every cycle:
- the field shapes and legal ranges of the three limit words;
- the live status bits in the options word;
- the learn-bit clear;
- that at most one strobe is high, and that no word moves without its strobe;
- that SDA is released whenever the link is idle or skipping a transfer.

Only the bench scenarios can show the protocol-level results: address matching, ACK placement, the low-byte-first order, the repeated-START read, identification values that ignore writes, and the exact values that writes at the range boundaries produce.

// File: rtl/smb_chg_pkg.sv
package smb_chg_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] CMD_OPT  = 8'h12;
  localparam logic [BYTE_W-1:0] CMD_ICHG = 8'h14;
  localparam logic [BYTE_W-1:0] CMD_VCHG = 8'h15;
  localparam logic [BYTE_W-1:0] CMD_IIN  = 8'h3F;
  localparam logic [BYTE_W-1:0] CMD_MFR  = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_DEV  = 8'hFF;

  localparam logic [WORD_W-1:0] RST_OPT  = 16'hF902;
  localparam logic [WORD_W-1:0] RST_IIN  = 16'h1000;
  localparam logic [WORD_W-1:0] ID_MFR   = 16'h0040;
  localparam logic [WORD_W-1:0] ID_DEV   = 16'h001B;

  localparam logic [WORD_W-1:0] MSK_ICHG = 16'h1FC0;
  localparam logic [WORD_W-1:0] MSK_VCHG = 16'h7FF0;
  localparam logic [WORD_W-1:0] MSK_IIN  = 16'h1F80;
  localparam logic [WORD_W-1:0] ICHG_MIN = 16'h0080;
  localparam logic [WORD_W-1:0] VCHG_MIN = 16'h0400;
  localparam logic [WORD_W-1:0] VCHG_MAX = 16'h4B00;

  localparam int OPT_LEARN_BIT = 6;
  localparam int OPT_ADP_BIT   = 4;
  localparam int OPT_BST_BIT   = 2;
  localparam logic [WORD_W-1:0] OPT_LIVE = (16'h1 << OPT_ADP_BIT) | (16'h1 << OPT_BST_BIT);

  typedef enum logic [1:0] {LS_IDLE, LS_RX, LS_TX, LS_SKIP} link_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DLO, PH_DHI} rx_ph_e;

  function automatic logic [WORD_W-1:0] fit_ichg(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] m;
    m = w & MSK_ICHG;
    return (m < ICHG_MIN) ? '0 : m;
  endfunction

  function automatic logic [WORD_W-1:0] fit_vchg(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] m;
    m = w & MSK_VCHG;
    return ((m < VCHG_MIN) || (m > VCHG_MAX)) ? '0 : m;
  endfunction

  function automatic logic [WORD_W-1:0] fit_iin(input logic [WORD_W-1:0] w);
    return w & MSK_IIN;
  endfunction

  function automatic logic [WORD_W-1:0] merge_opt(input logic [WORD_W-1:0] stored,
                                                  input logic adp, input logic bst);
    logic [WORD_W-1:0] v;
    v = stored & ~OPT_LIVE;
    v[OPT_ADP_BIT] = adp;
    v[OPT_BST_BIT] = bst;
    return v;
  endfunction
endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_chg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] cmd,
  output logic [WORD_W-1:0] wdata,
  output logic              wr_pulse,
  output logic              start_det,
  output logic              stop_det,
  output logic              link_quiet
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  logic scl_d, sda_d;
  logic scl_rise, scl_fall;
  link_st_e st;
  rx_ph_e   ph;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh, tx, lo_q, cmd_q;
  logic [WORD_W-1:0] snap, wdata_q;
  logic rnw, tx_hi, mack, oe_q, wr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= LS_IDLE; ph <= PH_ADDR; bitcnt <= '0;
      sh <= '0; tx <= '0; lo_q <= '0; cmd_q <= '0;
      snap <= '0; wdata_q <= '0;
      rnw <= 1'b0; tx_hi <= 1'b0; mack <= 1'b0; oe_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_det) begin
        st <= LS_RX; ph <= PH_ADDR; bitcnt <= '0; oe_q <= 1'b0;
      end else if (stop_det) begin
        st <= LS_IDLE; oe_q <= 1'b0;
      end else begin
        unique case (st)
          LS_RX: begin
            if (scl_rise && bitcnt < LAST_BIT) begin
              sh     <= {sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (ph == PH_ADDR && sh[BYTE_W-1:1] != DEV_ADDR) begin
                st <= LS_SKIP;
              end else begin
                oe_q   <= 1'b1;
                bitcnt <= ACK_SLOT;
                unique case (ph)
                  PH_ADDR: rnw     <= sh[0];
                  PH_CMD:  cmd_q   <= sh;
                  PH_DLO:  lo_q    <= sh;
                  PH_DHI:  wdata_q <= {sh, lo_q};
                endcase
              end
            end else if (scl_fall && bitcnt == ACK_SLOT) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              unique case (ph)
                PH_ADDR: begin
                  if (rnw) begin
                    st    <= LS_TX;
                    snap  <= rd_word;
                    tx    <= rd_word[BYTE_W-1:0];
                    oe_q  <= ~rd_word[BYTE_W-1];
                    tx_hi <= 1'b0;
                  end else begin
                    ph <= PH_CMD;
                  end
                end
                PH_CMD: ph <= PH_DLO;
                PH_DLO: ph <= PH_DHI;
                PH_DHI: begin
                  wr_q <= 1'b1;
                  st   <= LS_SKIP;
                end
              endcase
            end
          end
          LS_TX: begin
            if (scl_rise) begin
              if (bitcnt == LAST_BIT) begin
                mack   <= ~sda_s;
                bitcnt <= ACK_SLOT;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else if (scl_fall) begin
              if (bitcnt != '0 && bitcnt < LAST_BIT) begin
                tx   <= {tx[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx[BYTE_W-2];
              end else if (bitcnt == LAST_BIT) begin
                oe_q <= 1'b0;
              end else if (bitcnt == ACK_SLOT) begin
                if (mack && !tx_hi) begin
                  tx     <= snap[WORD_W-1:BYTE_W];
                  oe_q   <= ~snap[WORD_W-1];
                  tx_hi  <= 1'b1;
                  bitcnt <= '0;
                end else begin
                  st <= LS_SKIP;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe     = oe_q;
  assign cmd        = cmd_q;
  assign wdata      = wdata_q;
  assign wr_pulse   = wr_q;
  assign link_quiet = (st == LS_IDLE) || (st == LS_SKIP);
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_pulse,
  input  logic              sts_adapter,
  input  logic              sts_boost,
  input  logic              learn_done,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] opt_q,
  output logic [WORD_W-1:0] ichg_q,
  output logic [WORD_W-1:0] vchg_q,
  output logic [WORD_W-1:0] iin_q,
  output logic              wr_opt,
  output logic              wr_ichg,
  output logic              wr_vchg,
  output logic              wr_iin
);
  logic [WORD_W-1:0] opt_r, ichg_r, vchg_r, iin_r;
  logic hit_opt, hit_ichg, hit_vchg, hit_iin;

  assign hit_opt  = wr_pulse && cmd == CMD_OPT;
  assign hit_ichg = wr_pulse && cmd == CMD_ICHG;
  assign hit_vchg = wr_pulse && cmd == CMD_VCHG;
  assign hit_iin  = wr_pulse && cmd == CMD_IIN;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      opt_r  <= RST_OPT;
      ichg_r <= '0;
      vchg_r <= '0;
      iin_r  <= RST_IIN;
      wr_opt <= 1'b0; wr_ichg <= 1'b0; wr_vchg <= 1'b0; wr_iin <= 1'b0;
    end else begin
      wr_opt  <= hit_opt;
      wr_ichg <= hit_ichg;
      wr_vchg <= hit_vchg;
      wr_iin  <= hit_iin;
      if (hit_ichg) ichg_r <= fit_ichg(wdata);
      if (hit_vchg) vchg_r <= fit_vchg(wdata);
      if (hit_iin)  iin_r  <= fit_iin(wdata);
      if (hit_opt)  opt_r  <= wdata & ~OPT_LIVE;
      if (learn_done) opt_r[OPT_LEARN_BIT] <= 1'b0;
    end

  assign opt_q  = merge_opt(opt_r, sts_adapter, sts_boost);
  assign ichg_q = ichg_r;
  assign vchg_q = vchg_r;
  assign iin_q  = iin_r;

  always_comb begin
    unique case (cmd)
      CMD_OPT:  rd_word = opt_q;
      CMD_ICHG: rd_word = ichg_r;
      CMD_VCHG: rd_word = vchg_r;
      CMD_IIN:  rd_word = iin_r;
      CMD_MFR:  rd_word = ID_MFR;
      CMD_DEV:  rd_word = ID_DEV;
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/smb_chg_regs.sv
module smb_chg_regs
  import smb_chg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic        sts_adapter,
  input  logic        sts_boost,
  input  logic        learn_done,
  output logic [15:0] opt_q,
  output logic [15:0] ichg_q,
  output logic [15:0] vchg_q,
  output logic [15:0] iin_q,
  output logic        wr_opt,
  output logic        wr_ichg,
  output logic        wr_vchg,
  output logic        wr_iin
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pin_raw, pin_s;
  logic scl_s, sda_s;
  logic [BYTE_W-1:0] cmd;
  logic [WORD_W-1:0] wdata, rd_word;
  logic wr_pulse, start_det, stop_det, link_quiet;

  assign pin_raw = {sda_in, scl_in};

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw[p]), .q(pin_s[p])
      );
    end
  endgenerate

  assign scl_s = pin_s[0];
  assign sda_s = pin_s[1];

  smb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .rd_word(rd_word), .sda_oe(sda_oe), .cmd(cmd), .wdata(wdata),
    .wr_pulse(wr_pulse), .start_det(start_det), .stop_det(stop_det),
    .link_quiet(link_quiet)
  );

  smb_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(wdata), .wr_pulse(wr_pulse),
    .sts_adapter(sts_adapter), .sts_boost(sts_boost), .learn_done(learn_done),
    .rd_word(rd_word), .opt_q(opt_q), .ichg_q(ichg_q), .vchg_q(vchg_q),
    .iin_q(iin_q), .wr_opt(wr_opt), .wr_ichg(wr_ichg), .wr_vchg(wr_vchg),
    .wr_iin(wr_iin)
  );
endmodule

// File: rtl/smb_chg_regs_chk.sv
module smb_chg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        link_quiet,
  input logic        sts_adapter,
  input logic        sts_boost,
  input logic        learn_done,
  input logic [15:0] opt_q,
  input logic [15:0] ichg_q,
  input logic [15:0] vchg_q,
  input logic [15:0] iin_q,
  input logic        wr_opt,
  input logic        wr_ichg,
  input logic        wr_vchg,
  input logic        wr_iin
);
  AST_QUIET_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    link_quiet |-> !sda_oe); // R1

  AST_ICHG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (ichg_q[5:0] == 6'd0) && (ichg_q[15:13] == 3'd0) && (ichg_q == 16'd0 || ichg_q >= 16'h0080)); // R4

  AST_VCHG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (vchg_q[3:0] == 4'd0) && !vchg_q[15] && (vchg_q == 16'd0 || (vchg_q >= 16'h0400 && vchg_q <= 16'h4B00))); // R5

  AST_IIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (iin_q[6:0] == 7'd0) && (iin_q[15:13] == 3'd0)); // R6

  AST_OPT_LIVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q[4] == sts_adapter) && (opt_q[2] == sts_boost)); // R7

  AST_LEARN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    learn_done |=> !opt_q[6]); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_opt, wr_ichg, wr_vchg, wr_iin})); // R9

  AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ichg |=> !wr_ichg); // R9

  AST_ICHG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ichg_q) |-> wr_ichg); // R9

  AST_VCHG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vchg_q) |-> wr_vchg); // R9

  AST_IIN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iin_q) |-> wr_iin); // R9
endmodule

bind smb_chg_regs smb_chg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .link_quiet(link_quiet),
  .sts_adapter(sts_adapter), .sts_boost(sts_boost), .learn_done(learn_done),
  .opt_q(opt_q), .ichg_q(ichg_q), .vchg_q(vchg_q), .iin_q(iin_q),
  .wr_opt(wr_opt), .wr_ichg(wr_ichg), .wr_vchg(wr_vchg), .wr_iin(wr_iin)
);

// File: tb/test_smb_chg_regs.sv
`timescale 1ns/1ps
module test_smb_chg_regs;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sts_adapter = 1'b0, sts_boost = 1'b0, learn_done = 1'b0;
  logic sda_oe, sda_line;
  logic [15:0] opt_q, ichg_q, vchg_q, iin_q;
  logic wr_opt, wr_ichg, wr_vchg, wr_iin;
  int n_cmp = 0, n_bad = 0;
  int h_opt = 0, h_ichg = 0, h_vchg = 0, h_iin = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  smb_chg_regs i_smb_chg_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .sts_adapter(sts_adapter), .sts_boost(sts_boost), .learn_done(learn_done),
    .opt_q(opt_q), .ichg_q(ichg_q), .vchg_q(vchg_q), .iin_q(iin_q),
    .wr_opt(wr_opt), .wr_ichg(wr_ichg), .wr_vchg(wr_vchg), .wr_iin(wr_iin)
  );

  always @(posedge clk) begin
    if (wr_opt)  h_opt++;
    if (wr_ichg) h_ichg++;
    if (wr_vchg) h_vchg++;
    if (wr_iin)  h_iin++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait;
    m_sda = 1'b0; qwait; m_scl = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qwait; m_scl = 1'b1; qwait; m_sda = 1'b1; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait; m_scl = 1'b1; qwait; m_scl = 1'b0;
    end
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait;
    ack = ~sda_line;
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      qwait; m_scl = 1'b1; qwait;
      b = {b[6:0], sda_line};
      m_scl = 1'b0;
    end
    m_sda = ~mack; qwait; m_scl = 1'b1; qwait; m_scl = 1'b0; qwait;
    m_sda = 1'b1;
  endtask

  task automatic wr_word(input logic [7:0] cmd, input logic [15:0] val, output logic [3:0] acks);
    bus_start;
    send_byte(8'h12, acks[0]);
    send_byte(cmd, acks[1]);
    send_byte(val[7:0], acks[2]);
    send_byte(val[15:8], acks[3]);
    bus_stop;
    qwait;
  endtask

  task automatic rd_word(input logic [7:0] cmd, output logic [15:0] val, output logic [2:0] acks);
    logic [7:0] lo, hi;
    bus_start;
    send_byte(8'h12, acks[0]);
    send_byte(cmd, acks[1]);
    bus_start;
    send_byte(8'h13, acks[2]);
    recv_byte(1'b1, lo);
    recv_byte(1'b0, hi);
    bus_stop;
    qwait;
    val = {hi, lo};
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [2:0] a;
    chk("R2 opt reset", opt_q, 16'hF902);
    chk("R2 ichg reset", ichg_q, 16'h0000);
    chk("R2 vchg reset", vchg_q, 16'h0000);
    chk("R2 iin reset", iin_q, 16'h1000);
    chk("R1 idle no drive", {15'd0, sda_oe}, 16'h0000);
    rd_word(8'h3F, v, a);
    chk("R10 read acks", {13'd0, a}, 16'h0007);
    chk("R2 iin bus read", v, 16'h1000);
    rd_word(8'h12, v, a);
    chk("R2 opt bus read", v, 16'hF902);
  endtask

  task automatic t_ids;
    logic [15:0] v; logic [2:0] a; logic [3:0] w;
    rd_word(8'hFE, v, a);
    chk("R3 mfr id", v, 16'h0040);
    rd_word(8'hFF, v, a);
    chk("R3 dev id", v, 16'h001B);
    wr_word(8'hFE, 16'h1234, w);
    wr_word(8'hFF, 16'hABCD, w);
    rd_word(8'hFE, v, a);
    chk("R3 mfr after write", v, 16'h0040);
    rd_word(8'hFF, v, a);
    chk("R3 dev after write", v, 16'h001B);
  endtask

  task automatic t_ichg;
    logic [3:0] w; logic [15:0] v; logic [2:0] a;
    int o0, i0, c0, n0;
    o0 = h_opt; i0 = h_ichg; c0 = h_vchg; n0 = h_iin;
    wr_word(8'h14, 16'hFFFF, w);
    chk("R10 write acks", {12'd0, w}, 16'h000F);
    chk("R4 ichg mask", ichg_q, 16'h1FC0);
    chk("R9 ichg strobe one cycle", 16'(h_ichg - i0), 16'd1);
    chk("R9 other strobes quiet", 16'((h_opt - o0) + (h_vchg - c0) + (h_iin - n0)), 16'd0);
    rd_word(8'h14, v, a);
    chk("R10 ichg low byte first", v, 16'h1FC0);
    wr_word(8'h14, 16'h00BF, w);
    chk("R4 ichg at minimum", ichg_q, 16'h0080);
    wr_word(8'h14, 16'h007F, w);
    chk("R4 ichg below minimum clears", ichg_q, 16'h0000);
  endtask

  task automatic t_vchg;
    logic [3:0] w;
    wr_word(8'h15, 16'h3FFF, w);
    chk("R5 vchg mask", vchg_q, 16'h3FF0);
    wr_word(8'h15, 16'h4B0F, w);
    chk("R5 vchg at maximum", vchg_q, 16'h4B00);
    wr_word(8'h15, 16'h4B10, w);
    chk("R5 vchg above maximum clears", vchg_q, 16'h0000);
    wr_word(8'h15, 16'h040F, w);
    chk("R5 vchg at minimum", vchg_q, 16'h0400);
    wr_word(8'h15, 16'h03FF, w);
    chk("R5 vchg below minimum clears", vchg_q, 16'h0000);
  endtask

  task automatic t_iin;
    logic [3:0] w; int n0;
    n0 = h_iin;
    wr_word(8'h3F, 16'hFFFF, w);
    chk("R6 iin mask", iin_q, 16'h1F80);
    chk("R9 iin strobe", 16'(h_iin - n0), 16'd1);
  endtask

  task automatic t_opt;
    logic [3:0] w; logic [15:0] v; logic [2:0] a;
    wr_word(8'h12, 16'h0014, w);
    chk("R7 written status bits ignored", opt_q, 16'h0000);
    sts_adapter = 1'b1;
    qwait;
    chk("R7 adapter live", opt_q, 16'h0010);
    sts_boost = 1'b1;
    rd_word(8'h12, v, a);
    chk("R7 boost live over bus", v, 16'h0014);
    sts_boost = 1'b0;
    qwait;
  endtask

  task automatic t_learn;
    logic [3:0] w;
    wr_word(8'h12, 16'h0840, w);
    chk("R8 learn set", opt_q, 16'h0850);
    @(posedge clk); #1 learn_done = 1'b1;
    @(posedge clk); #1 learn_done = 1'b0;
    @(posedge clk); #1;
    chk("R8 learn cleared", opt_q, 16'h0810);
  endtask

  task automatic t_bad_addr;
    logic a0, a1, a2, a3; int i0;
    i0 = h_ichg;
    bus_start;
    send_byte(8'h20, a0);
    send_byte(8'h14, a1);
    send_byte(8'hC0, a2);
    send_byte(8'h03, a3);
    bus_stop;
    qwait;
    chk("R1 foreign address nack", {12'd0, a0, a1, a2, a3}, 16'h0000);
    chk("R1 foreign write ignored", ichg_q, 16'h0000);
    chk("R1 no strobe on foreign", 16'(h_ichg - i0), 16'd0);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset;
    t_ids;
    t_ichg;
    t_vchg;
    t_iin;
    t_opt;
    t_learn;
    t_bad_addr;
    done = 1'b1;
    finish_up;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up;
    end
  end
endmodule